// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power mode a small microcontroller is in and drives the clock enables, the oscillator enable and the peripheral reset that follow from that mode. The CPU requests a low-power mode with a one-cycle sleep strobe. A select bit sampled with that strobe picks one of two depths. In light sleep only the CPU clock stops. In deep standby every clock and the oscillator stop, and the peripherals are held in reset.

Wake-up requests are qualified against the depth and against the interrupt mask captured at the strobe. Leaving deep standby through an interrupt first restarts the oscillator. A counter then waits a programmable settling time before clocks return and interrupt handling begins. Two external pins override everything. A standby pin forces a hardware standby in which all outputs are off. A reset pin forces a reset hold, and the reset-exception pulse comes only when that pin is released.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous reset `rst` the block is active: cpu_clk_en, per_clk_en and osc_en are 1, per_rst is 0 and both exception pulses are 0.
- R2: A sleep_req with sby_sel=0 enters light sleep on the next rising edge: cpu_clk_en 0, per_clk_en 1, osc_en 1, per_rst 0.
- R3: In light sleep a peripheral request per_irq[i] wakes the block only if per_ien[i] is 1. A wake makes cpu_clk_en 1 and raises irq_exc_start on the next edge, and the pulse lasts exactly one cycle.
- R4: If imask was 1 at the sleep strobe, only nmi wakes the block from light sleep; enabled peripheral requests and ext_irq lines are ignored.
- R5: A sleep_req with sby_sel=1 enters deep standby on the next edge: cpu_clk_en 0, per_clk_en 0, osc_en 0, per_rst 1.
- R6: In deep standby peripheral requests have no effect, even when enabled; only nmi or any ext_irq line starts a wake.
- R7: On an nmi/ext_irq wake from deep standby, osc_en rises on the next edge while per_rst stays 1. cpu_clk_en and irq_exc_start rise exactly 2^(SETTLE_BASE_LOG2+min(settle_sel,4)) edges later. Codes 0..4 give 2^13..2^17 cycles at the default base, and codes 5..7 behave like code 4.
- R8: rst_pin_n low enters the reset hold on the next edge: cpu_clk_en 0, per_clk_en 0, osc_en 1, per_rst 1. On the edge after the pin returns high the block goes active with a single-cycle rst_exc_start.
- R9: sby_pin_n low in any mode enters hardware standby on the next edge: all clock enables and osc_en 0, per_rst 1. This overrides rst_pin_n. On release the block passes through the reset hold, as in R8.
- R10: rst_pin_n low takes priority over a simultaneous wake request: the block enters the reset hold and no irq_exc_start is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req | input | 1 | One-cycle request to enter a low-power mode |
| sby_sel | input | 1 | Depth select at sleep_req: 0 light sleep, 1 deep standby |
| settle_sel | input | SEL_W | Oscillator settling-time code |
| imask | input | 1 | CPU interrupt mask, captured at sleep_req |
| per_irq | input | N_SRC | Peripheral interrupt requests |
| per_ien | input | N_SRC | Per-source interrupt enables |
| nmi | input | 1 | Non-maskable interrupt |
| ext_irq | input | N_EXT | External interrupt lines |
| rst_pin_n | input | 1 | Active-low reset pin |
| sby_pin_n | input | 1 | Active-low hardware standby pin |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| per_rst | output | 1 | Peripheral reset |
| rst_exc_start | output | 1 | One-cycle start of reset exception handling |
| irq_exc_start | output | 1 | One-cycle start of interrupt exception handling |

## Verification
Every mode change, and every pulse, appears on the outputs on the first rising edge after the stimulus, because the outputs are registered from the next mode. The settling delay is the one exception: it is measured in edges from the rise of osc_en. The bench changes inputs on falling edges and queues each expectation at the edge where the result is due. A monitor compares it at the following falling edge. For the settling window, the bench counts rising edges from the osc_en rise until cpu_clk_en appears and compares that count with the computed power of two.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [2:0] {
    PM_ACTIVE  = 3'd0,
    PM_SLEEP   = 3'd1,
    PM_SWSBY   = 3'd2,
    PM_SETTLE  = 3'd3,
    PM_RSTHOLD = 3'd4,
    PM_HWSBY   = 3'd5
  } pm_state_e;

  typedef struct packed {
    logic cpu_clk_en;
    logic per_clk_en;
    logic osc_en;
    logic per_rst;
  } pm_ctl_t;

  function automatic pm_ctl_t ctl_of(input pm_state_e s);
    pm_ctl_t c;
    case (s)
      PM_ACTIVE:  c = '{cpu_clk_en: 1'b1, per_clk_en: 1'b1, osc_en: 1'b1, per_rst: 1'b0};
      PM_SLEEP:   c = '{cpu_clk_en: 1'b0, per_clk_en: 1'b1, osc_en: 1'b1, per_rst: 1'b0};
      PM_SETTLE:  c = '{cpu_clk_en: 1'b0, per_clk_en: 1'b0, osc_en: 1'b1, per_rst: 1'b1};
      PM_RSTHOLD: c = '{cpu_clk_en: 1'b0, per_clk_en: 1'b0, osc_en: 1'b1, per_rst: 1'b1};
      default:    c = '{cpu_clk_en: 1'b0, per_clk_en: 1'b0, osc_en: 1'b0, per_rst: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
  parameter int N_SRC = 4,
  parameter int N_EXT = 3
) (
  input  logic [N_SRC-1:0] per_irq,
  input  logic [N_SRC-1:0] per_ien,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             nmi,
  input  logic             mask_lat,
  output logic             sleep_wake,
  output logic             sby_wake
);

  logic [N_SRC-1:0] per_hit;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign per_hit[g] = per_irq[g] & per_ien[g];
    end
  endgenerate

  logic maskable_req;
  assign maskable_req = (|per_hit) | (|ext_irq);

  // light sleep: any enabled source unless masked; nmi always
  assign sleep_wake = nmi | (~mask_lat & maskable_req);
  // deep standby: only nmi and external lines
  assign sby_wake   = nmi | (|ext_irq);

endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int SEL_W           = 3,
  parameter int SETTLE_BASE_LOG2 = 13,
  parameter int MAX_CODE        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);

  localparam int CNT_W = SETTLE_BASE_LOG2 + MAX_CODE + 1;

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] span(input logic [SEL_W-1:0] c);
    int e;
    e = (int'(c) > MAX_CODE) ? MAX_CODE : int'(c);
    return (CNT_W'(1) << (SETTLE_BASE_LOG2 + e)) - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= span(sel);
    end else if (run && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R7

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic sby_sel,
  input  logic imask,
  input  logic sleep_wake,
  input  logic sby_wake,
  input  logic settle_done,
  input  logic rst_pin_n,
  input  logic sby_pin_n,
  output logic mask_lat,
  output logic settle_load,
  output logic settle_run,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_en,
  output logic per_rst,
  output logic rst_exc_start,
  output logic irq_exc_start
);

  pm_state_e state, nxt;
  logic      rst_pulse_d, irq_pulse_d;
  pm_ctl_t   ctl_d;

  always_comb begin
    nxt         = state;
    settle_load = 1'b0;
    rst_pulse_d = 1'b0;
    irq_pulse_d = 1'b0;
    if (!sby_pin_n) begin
      nxt = PM_HWSBY;
    end else if (state == PM_HWSBY) begin
      nxt = PM_RSTHOLD;
    end else if (!rst_pin_n) begin
      nxt = PM_RSTHOLD;
    end else begin
      case (state)
        PM_ACTIVE: if (sleep_req) nxt = sby_sel ? PM_SWSBY : PM_SLEEP;
        PM_SLEEP: if (sleep_wake) begin
          nxt         = PM_ACTIVE;
          irq_pulse_d = 1'b1;
        end
        PM_SWSBY: if (sby_wake) begin
          nxt         = PM_SETTLE;
          settle_load = 1'b1;
        end
        PM_SETTLE: if (settle_done) begin
          nxt         = PM_ACTIVE;
          irq_pulse_d = 1'b1;
        end
        PM_RSTHOLD: begin
          nxt         = PM_ACTIVE;
          rst_pulse_d = 1'b1;
        end
        default: nxt = PM_RSTHOLD;
      endcase
    end
  end

  assign ctl_d      = ctl_of(nxt);
  assign settle_run = (state == PM_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= PM_ACTIVE;
      mask_lat      <= 1'b0;
      cpu_clk_en    <= 1'b1;
      per_clk_en    <= 1'b1;
      osc_en        <= 1'b1;
      per_rst       <= 1'b0;
      rst_exc_start <= 1'b0;
      irq_exc_start <= 1'b0;
    end else begin
      state         <= nxt;
      if (state == PM_ACTIVE && sleep_req) mask_lat <= imask;
      cpu_clk_en    <= ctl_d.cpu_clk_en;
      per_clk_en    <= ctl_d.per_clk_en;
      osc_en        <= ctl_d.osc_en;
      per_rst       <= ctl_d.per_rst;
      rst_exc_start <= rst_pulse_d;
      irq_exc_start <= irq_pulse_d;
    end
  end

  AST_RST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    rst_exc_start |=> !rst_exc_start); // R8
  AST_IRQ_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    irq_exc_start |=> !irq_exc_start); // R3
  AST_HWSBY_PRIO: assert property (@(posedge clk) disable iff (rst)
    !sby_pin_n |=> (!osc_en && !cpu_clk_en && per_rst)); // R9
  AST_RSTPIN_PRIO: assert property (@(posedge clk) disable iff (rst)
    (sby_pin_n && !rst_pin_n) |=> (osc_en && !cpu_clk_en && !irq_exc_start)); // R10
  AST_PERRST_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    per_rst |-> (!per_clk_en && !cpu_clk_en)); // R5
  AST_SETTLE_HOLDS_RST: assert property (@(posedge clk) disable iff (rst)
    (state == PM_SETTLE) |-> (per_rst && osc_en)); // R7

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int N_SRC            = 4,
  parameter int N_EXT            = 3,
  parameter int SEL_W            = 3,
  parameter int SETTLE_BASE_LOG2 = 13,
  parameter int MAX_CODE         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             sby_sel,
  input  logic [SEL_W-1:0] settle_sel,
  input  logic             imask,
  input  logic [N_SRC-1:0] per_irq,
  input  logic [N_SRC-1:0] per_ien,
  input  logic             nmi,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             rst_pin_n,
  input  logic             sby_pin_n,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic             per_rst,
  output logic             rst_exc_start,
  output logic             irq_exc_start
);

  logic mask_lat, sleep_wake, sby_wake;
  logic settle_load, settle_run, settle_done;

  pmc_wake_qual #(.N_SRC(N_SRC), .N_EXT(N_EXT)) u_wake (
    .per_irq    (per_irq),
    .per_ien    (per_ien),
    .ext_irq    (ext_irq),
    .nmi        (nmi),
    .mask_lat   (mask_lat),
    .sleep_wake (sleep_wake),
    .sby_wake   (sby_wake)
  );

  pmc_settle_timer #(
    .SEL_W(SEL_W), .SETTLE_BASE_LOG2(SETTLE_BASE_LOG2), .MAX_CODE(MAX_CODE)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (settle_load),
    .run  (settle_run),
    .sel  (settle_sel),
    .done (settle_done)
  );

  pmc_mode_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .sleep_req     (sleep_req),
    .sby_sel       (sby_sel),
    .imask         (imask),
    .sleep_wake    (sleep_wake),
    .sby_wake      (sby_wake),
    .settle_done   (settle_done),
    .rst_pin_n     (rst_pin_n),
    .sby_pin_n     (sby_pin_n),
    .mask_lat      (mask_lat),
    .settle_load   (settle_load),
    .settle_run    (settle_run),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .osc_en        (osc_en),
    .per_rst       (per_rst),
    .rst_exc_start (rst_exc_start),
    .irq_exc_start (irq_exc_start)
  );

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sleep_req = 1'b0, sby_sel = 1'b0, imask = 1'b0, nmi = 1'b0;
  logic [2:0] settle_sel = 3'd0;
  logic [3:0] per_irq = 4'd0, per_ien = 4'd0;
  logic [2:0] ext_irq = 3'd0;
  logic       rst_pin_n = 1'b1, sby_pin_n = 1'b1;
  logic       cpu_clk_en, per_clk_en, osc_en, per_rst, rst_exc_start, irq_exc_start;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_BASE_LOG2(BASE)) u_pwr_mode_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sby_sel(sby_sel),
    .settle_sel(settle_sel), .imask(imask), .per_irq(per_irq), .per_ien(per_ien),
    .nmi(nmi), .ext_irq(ext_irq), .rst_pin_n(rst_pin_n), .sby_pin_n(sby_pin_n),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .per_rst(per_rst), .rst_exc_start(rst_exc_start), .irq_exc_start(irq_exc_start)
  );

  // {cpu_clk_en, per_clk_en, osc_en, per_rst, rst_exc_start, irq_exc_start}
  localparam logic [5:0] ACT = 6'b111000;
  localparam logic [5:0] SLP = 6'b011000;
  localparam logic [5:0] SBY = 6'b000100;
  localparam logic [5:0] STL = 6'b001100;
  localparam logic [5:0] RSH = 6'b001100;
  localparam logic [5:0] HSB = 6'b000100;
  localparam logic [5:0] IXC = 6'b000001;
  localparam logic [5:0] RXC = 6'b000010;

  typedef struct {
    string      tag;
    logic [5:0] exp;
  } item_t;

  item_t sbq[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  logic  done_flag = 1'b0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver side: result due at this rising edge, queued for the monitor
  task automatic due(string tag, logic [5:0] exp);
    item_t it;
    @(posedge clk);
    it.tag = tag;
    it.exp = exp;
    sbq.push_back(it);
  endtask

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        logic [5:0] act;
        it  = sbq.pop_front();
        act = {cpu_clk_en, per_clk_en, osc_en, per_rst, rst_exc_start, irq_exc_start};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic enter(logic deep, logic [2:0] sel);
    @(negedge clk);
    sby_sel = deep; settle_sel = sel; sleep_req = 1'b1;
    due(deep ? "R5 enter deep" : "R2 enter sleep", deep ? SBY : SLP);
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic settle_run(logic [2:0] sel, int exp_n, logic use_nmi);
    int n;
    enter(1'b1, sel);
    per_irq = 4'b1111; per_ien = 4'b1111;
    due("R6 enabled peripheral ignored", SBY);
    due("R6 enabled peripheral ignored", SBY);
    @(negedge clk);
    per_irq = 4'd0; per_ien = 4'd0;
    if (use_nmi) nmi = 1'b1; else ext_irq = 3'b100;
    due("R7 oscillator restarts", STL);
    @(negedge clk);
    nmi = 1'b0; ext_irq = 3'd0;
    n = 1;
    while (!cpu_clk_en && n < 1000) begin
      @(posedge clk);
      #1;
      if (!cpu_clk_en) n++;
    end
    check("R7 settle edges", n, exp_n);
    check("R7 irq pulse with clock", int'(irq_exc_start), 1);
    @(negedge clk);
    due("R7 pulse over", ACT);
    sby_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    due("R1 reset state", ACT);

    // light sleep, enable gating, single pulse
    enter(1'b0, 3'd0);
    per_irq = 4'b0010; per_ien = 4'b1101;
    due("R3 disabled source", SLP);
    due("R3 disabled source", SLP);
    @(negedge clk);
    per_ien = 4'b0010;
    due("R3 enabled wake", ACT | IXC);
    @(negedge clk);
    per_irq = 4'd0; per_ien = 4'd0;
    due("R3 pulse one cycle", ACT);

    // mask captured at strobe
    @(negedge clk);
    imask = 1'b1;
    enter(1'b0, 3'd0);
    imask = 1'b0;
    per_irq = 4'b0001; per_ien = 4'b0001; ext_irq = 3'b010;
    due("R4 masked ignored", SLP);
    due("R4 masked ignored", SLP);
    @(negedge clk);
    nmi = 1'b1;
    due("R4 nmi wakes", ACT | IXC);
    @(negedge clk);
    nmi = 1'b0; per_irq = 4'd0; per_ien = 4'd0; ext_irq = 3'd0;
    due("R4 pulse over", ACT);

    // deep standby settling windows
    settle_run(3'd1, 1 << (BASE + 1), 1'b0);
    settle_run(3'd0, 1 << BASE, 1'b1);
    settle_run(3'd6, 1 << (BASE + 4), 1'b0);

    // reset pin from deep standby
    enter(1'b1, 3'd0);
    rst_pin_n = 1'b0;
    due("R8 reset hold", RSH);
    due("R8 reset hold", RSH);
    due("R8 reset hold", RSH);
    @(negedge clk);
    rst_pin_n = 1'b1;
    due("R8 release pulse", ACT | RXC);
    due("R8 pulse over", ACT);

    // reset pin beats simultaneous nmi in light sleep
    enter(1'b0, 3'd0);
    rst_pin_n = 1'b0; nmi = 1'b1;
    due("R10 reset over wake", RSH);
    @(negedge clk);
    nmi = 1'b0; rst_pin_n = 1'b1;
    due("R10 reset exit", ACT | RXC);
    due("R10 pulse over", ACT);

    // hardware standby from deep standby, over reset pin
    enter(1'b1, 3'd0);
    sby_pin_n = 1'b0; rst_pin_n = 1'b0;
    due("R9 hw standby", HSB);
    due("R9 hw standby", HSB);
    @(negedge clk);
    sby_pin_n = 1'b1; rst_pin_n = 1'b1;
    due("R9 via reset hold", RSH);
    due("R9 reset exit", ACT | RXC);
    due("R9 pulse over", ACT);

    // hardware standby from active
    @(negedge clk);
    sby_pin_n = 1'b0;
    due("R9 from active", HSB);
    @(negedge clk);
    sby_pin_n = 1'b1;
    due("R9 via reset hold", RSH);
    due("R9 reset exit", ACT | RXC);

    repeat (2) @(negedge clk);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule